// File: doc/BRIEF.md
# Remote-Control Pulse and Symbol Capture Receiver

This block watches a demodulated remote-control input (infrared or radio) and measures every symbol in a pulse train. A symbol starts when the carrier appears. The block records two durations for it: the active (carrier-present) time and the full period up to the start of the next active phase. The idle gap is not stored, because software gets it by subtracting the first count from the second. Every duration is counted in sample ticks. An integer divisor derives these ticks from the system clock, and the nominal rate is 10 MHz.

Measured pairs go into a small FIFO that software empties over a simple register bus. When no new active phase starts within a programmable maximum period, the train is treated as finished. The block then stores one last entry whose period field holds the reserved all-ones value and raises a last-symbol status bit. One level interrupt output combines the four status bits with their enables.

Top module: `ir_capture_rx`

## Requirements
- R1: After reset all control, enable and status registers read zero, the FIFO is empty (status register reads 0x0000) and `irq` is low.
- R2: With the receiver enabled, each symbol is stored as a pair. The active count is the number of sample ticks the corrected input stays high. The period count is the number of ticks from one rising edge of the corrected input to the next. Pairs leave the FIFO in arrival order.
- R3: If no rising edge arrives within MAXPER ticks (address 2) after the last one, a pair holding the measured active count and period 0xFFFF is stored, and status bit 1 is set.
- R4: Setting bit 1 of CTRL (address 0) inverts the raw input, so a low pin counts as carrier present.
- R5: Capture runs only while bit 0 of CTRL is set; with it clear nothing is stored. A line that is already active when the receiver is enabled does not start a symbol.
- R6: A sample tick occurs every DIV clocks (address 1); DIV values 0 and 1 both give one tick per clock.
- R7: The FIFO holds 8 pairs. Reading SYM (address 7) returns the head period without removing it. Reading ACT (address 8) returns the head active count and removes the entry. Both read 0 when the FIFO is empty.
- R8: A pair that arrives while the FIFO is full is dropped and sets status bit 2 (overrun). The store that fills the FIFO sets status bit 3 (full).
- R9: Status (address 4) bit 0 is set by every stored pair. Writing ones to CLR (address 5) clears the matching status bits and leaves the others untouched.
- R10: `irq` is high exactly when some status bit and the same bit of IEN (address 3) are both set.
- R11: The receive status register (address 6) shows the FIFO fill level in bits 15:8 and the overrun status in bit 2.
- R12: Active and period counters saturate at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated remote-control input, asynchronous |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of ACT pops) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high, zero otherwise |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 16-bit counters, an 8-deep FIFO and an 8-bit divisor. It programs divisors of 1, 4 and 0 and a maximum period of 40 ticks. With the short maximum period, end-of-train entries appear after a few dozen clocks. Ten symbols are enough to fill the 8-entry FIFO and show overrun. A divisor of 1 lets a single held-active phase of about 66,000 clocks drive both counters into saturation within the run.

// File: rtl/ircap_pkg.sv
package ircap_pkg;

  localparam int BUS_W = 16;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_DIV    = 4'd1,
    A_MAXP   = 4'd2,
    A_IEN    = 4'd3,
    A_ISTAT  = 4'd4,
    A_ICLR   = 4'd5,
    A_RXSTAT = 4'd6,
    A_SYM    = 4'd7,
    A_ACT    = 4'd8
  } reg_addr_e;

  localparam int IB_SYM  = 0;
  localparam int IB_LAST = 1;
  localparam int IB_OVR  = 2;
  localparam int IB_FULL = 3;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_MARK  = 2'd1,
    M_SPACE = 2'd2
  } meas_state_e;

endpackage

// File: rtl/ircap_prescale.sv
module ircap_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap = ({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, div};
    tick = run && wrap;
    if (!run || wrap) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: with a divisor above one, ticks never come on adjacent clocks
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > DIV_W'(1)) |=> (!tick || div != $past(div)));

endmodule

// File: rtl/ircap_measure.sv
module ircap_measure
  import ircap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             invert,
  input  logic             ir_in,
  input  logic             tick,
  input  logic [CNT_W-1:0] max_per,
  output logic             push,
  output logic [CNT_W-1:0] push_mark,
  output logic [CNT_W-1:0] push_sym,
  output logic             push_last
);

  logic             s1_q, s2_q;
  logic             lvl, prev_q, prev_d, rise;
  meas_state_e      st_q, st_d;
  logic [CNT_W-1:0] mark_q, mark_d, sym_q, sym_d;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= ir_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    lvl    = s2_q ^ invert;
    rise   = lvl && !prev_q;
    prev_d = (!enable || tick) ? lvl : prev_q;
  end

  always_comb begin
    st_d      = st_q;
    mark_d    = mark_q;
    sym_d     = sym_q;
    push      = 1'b0;
    push_last = 1'b0;
    push_mark = mark_q;
    push_sym  = sym_q;
    if (!enable) begin
      st_d   = M_IDLE;
      mark_d = '0;
      sym_d  = '0;
    end else if (tick) begin
      case (st_q)
        M_IDLE: begin
          if (rise) begin
            st_d   = M_MARK;
            mark_d = CNT_W'(1);
            sym_d  = CNT_W'(1);
          end
        end
        M_MARK: begin
          sym_d = sat_inc(sym_q);
          if (lvl) mark_d = sat_inc(mark_q);
          else     st_d   = M_SPACE;
        end
        M_SPACE: begin
          if (rise) begin
            push   = 1'b1;
            st_d   = M_MARK;
            mark_d = CNT_W'(1);
            sym_d  = CNT_W'(1);
          end else if (sym_q >= max_per) begin
            push      = 1'b1;
            push_last = 1'b1;
            push_sym  = '1;
            st_d      = M_IDLE;
            mark_d    = '0;
            sym_d     = '0;
          end else begin
            sym_d = sat_inc(sym_q);
          end
        end
        default: st_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      st_q   <= M_IDLE;
      mark_q <= '0;
      sym_q  <= '0;
    end else begin
      prev_q <= prev_d;
      st_q   <= st_d;
      mark_q <= mark_d;
      sym_q  <= sym_d;
    end
  end

  // R2: a completed symbol always has a period longer than its active time
  assert_mark_below_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !push_last) |-> (push_mark < push_sym));

  // R3: an end-of-train entry only follows an expired maximum period
  assert_timeout_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_last |-> (push && push_sym == '1 && sym_q >= max_per));

endmodule

// File: rtl/ircap_fifo.sv
module ircap_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [W-1:0]                 wdata,
  input  logic                         rd,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic                         full,
  output logic                         drop,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          wr_ok, rd_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    full  = (fill_q == CW'(DEPTH));
    empty = (fill_q == '0);
    wr_ok = wr && !full;
    rd_ok = rd && !empty;
    drop  = wr && full;
    wp_d  = wr_ok ? nxt(wp_q) : wp_q;
    rp_d  = rd_ok ? nxt(rp_q) : rp_q;
    case ({wr_ok, rd_ok})
      2'b10:   fill_d = fill_q + CW'(1);
      2'b01:   fill_d = fill_q - CW'(1);
      default: fill_d = fill_q;
    endcase
    rdata = mem[rp_q];
    fill  = fill_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wdata;
  end

  // R7: occupancy never exceeds the configured depth
  assert_fill_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));

  // R8: a write into a full FIFO without a read leaves it full
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> full);

endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx
  import ircap_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16,
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);

  localparam int CW    = $clog2(DEPTH+1);
  localparam int ENT_W = 2 * CNT_W;

  logic             en_q, en_d, inv_q, inv_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] maxp_q, maxp_d;
  logic [3:0]       ien_q, ien_d, ist_q, ist_d, ist_set, ist_clr;

  logic             tick;
  logic             m_push, m_last;
  logic [CNT_W-1:0] m_mark, m_sym;
  logic [ENT_W-1:0] f_head;
  logic             f_empty, f_full, f_drop, f_pop, f_wr_ok;
  logic [CW-1:0]    f_fill;
  reg_addr_e        addr;

  ircap_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en_q),
    .div  (div_q),
    .tick (tick)
  );

  ircap_measure #(.CNT_W(CNT_W)) u_meas (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (en_q),
    .invert   (inv_q),
    .ir_in    (ir_in),
    .tick     (tick),
    .max_per  (maxp_q),
    .push     (m_push),
    .push_mark(m_mark),
    .push_sym (m_sym),
    .push_last(m_last)
  );

  ircap_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (m_push),
    .wdata({m_mark, m_sym}),
    .rd   (f_pop),
    .rdata(f_head),
    .empty(f_empty),
    .full (f_full),
    .drop (f_drop),
    .fill (f_fill)
  );

  always_comb begin
    addr    = reg_addr_e'(bus_addr);
    f_pop   = bus_rd && (addr == A_ACT);
    f_wr_ok = m_push && !f_full;

    en_d   = en_q;
    inv_d  = inv_q;
    div_d  = div_q;
    maxp_d = maxp_q;
    ien_d  = ien_q;
    ist_clr = 4'b0;
    if (bus_wr) begin
      case (addr)
        A_CTRL: begin
          en_d  = bus_wdata[0];
          inv_d = bus_wdata[1];
        end
        A_DIV:   div_d   = bus_wdata[DIV_W-1:0];
        A_MAXP:  maxp_d  = bus_wdata[CNT_W-1:0];
        A_IEN:   ien_d   = bus_wdata[3:0];
        A_ICLR:  ist_clr = bus_wdata[3:0];
        default: ;
      endcase
    end

    ist_set           = 4'b0;
    ist_set[IB_SYM]   = f_wr_ok;
    ist_set[IB_LAST]  = m_push && m_last;
    ist_set[IB_OVR]   = f_drop;
    ist_set[IB_FULL]  = f_wr_ok && (f_fill == CW'(DEPTH-1));
    ist_d = (ist_q & ~ist_clr) | ist_set;

    irq = |(ist_q & ien_q);
  end

  always_comb begin
    bus_rdata = 16'h0;
    if (bus_rd) begin
      case (addr)
        A_CTRL:   bus_rdata = {14'b0, inv_q, en_q};
        A_DIV:    bus_rdata = 16'(div_q);
        A_MAXP:   bus_rdata = 16'(maxp_q);
        A_IEN:    bus_rdata = {12'b0, ien_q};
        A_ISTAT:  bus_rdata = {12'b0, ist_q};
        A_RXSTAT: bus_rdata = {8'(f_fill), 5'b0, ist_q[IB_OVR], 2'b0};
        A_SYM:    bus_rdata = f_empty ? 16'h0 : 16'(f_head[CNT_W-1:0]);
        A_ACT:    bus_rdata = f_empty ? 16'h0 : 16'(f_head[ENT_W-1:CNT_W]);
        default:  bus_rdata = 16'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      inv_q  <= 1'b0;
      div_q  <= '0;
      maxp_q <= '0;
      ien_q  <= '0;
      ist_q  <= '0;
    end else begin
      en_q   <= en_d;
      inv_q  <= inv_d;
      div_q  <= div_d;
      maxp_q <= maxp_d;
      ien_q  <= ien_d;
      ist_q  <= ist_d;
    end
  end

  // R5: nothing is measured while the receiver is switched off
  assert_off_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !m_push);

  // R10: with every enable clear the interrupt stays low
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 4'b0) |-> !irq);

  // R8: overrun status persists until software clears it
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_q[IB_OVR] && !(bus_wr && addr == A_ICLR && bus_wdata[IB_OVR])) |=> ist_q[IB_OVR]);

endmodule

// File: tb/ir_capture_rx_tb_top.sv
module ir_capture_rx_tb_top;

  localparam logic [3:0] CTRL = 4'd0, DIVR = 4'd1, MAXP = 4'd2, IEN = 4'd3,
                         ISTAT = 4'd4, ICLR = 4'd5, RXST = 4'd6, SYM = 4'd7, ACT = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;

  int          checks = 0;
  int          errors = 0;
  logic        act = 1'b1;
  logic [31:0] expq[$];

  ir_capture_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int on_clk, input int off_clk);
    ir_in = act;
    idle(on_clk);
    ir_in = ~act;
    idle(off_clk);
  endtask

  task automatic expect_pair(input int m, input int s);
    expq.push_back({16'(m), 16'(s)});
  endtask

  task automatic drain(input string req);
    logic [15:0] d;
    logic [31:0] e;
    while (expq.size() > 0) begin
      e = expq.pop_front();
      rd(SYM, d); check({req, " period"}, 32'(d), 32'(e[15:0]));
      rd(ACT, d); check({req, " active"}, 32'(d), 32'(e[31:16]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    rd(RXST, d);  check("R1 rxstatus", 32'(d), 32'h0);
    rd(ISTAT, d); check("R1 status", 32'(d), 32'h0);
    rd(CTRL, d);  check("R1 ctrl", 32'(d), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2, R3: basic train, one tick per clock
    wr(DIVR, 16'd1); wr(MAXP, 16'd40); wr(IEN, 16'd0); wr(CTRL, 16'd1);
    idle(5);
    pulse(5, 7);  expect_pair(5, 12);
    pulse(9, 4);  expect_pair(9, 13);
    pulse(3, 60); expect_pair(3, 16'hFFFF);
    idle(6);
    rd(RXST, d);  check("R11 fill three", 32'(d), 32'h0300);
    rd(ISTAT, d); check("R9 R3 status sym+last", 32'(d), 32'h3);
    check("R10 irq masked", 32'(irq), 32'h0);
    wr(IEN, 16'h2);
    check("R10 irq on last", 32'(irq), 32'h1);
    rd(SYM, d);   check("R7 peek no pop", 32'(d), 32'd12);
    drain("R2");
    rd(SYM, d);   check("R7 empty period", 32'(d), 32'h0);
    rd(ACT, d);   check("R7 empty active", 32'(d), 32'h0);
    wr(ICLR, 16'h1);
    rd(ISTAT, d); check("R9 clear bit0 only", 32'(d), 32'h2);
    check("R10 irq still", 32'(irq), 32'h1);
    wr(ICLR, 16'h2);
    check("R10 irq cleared", 32'(irq), 32'h0);

    // R4: inverted polarity
    wr(CTRL, 16'd0);
    ir_in = 1'b1; act = 1'b0;
    idle(4);
    wr(CTRL, 16'd2); idle(4); wr(CTRL, 16'd3); idle(5);
    pulse(6, 10); expect_pair(6, 16);
    pulse(4, 50); expect_pair(4, 16'hFFFF);
    idle(6);
    drain("R4");

    // R5: disabled receiver, and enable while line active
    wr(ICLR, 16'hF);
    wr(CTRL, 16'd2);
    pulse(5, 5); pulse(5, 5); pulse(5, 50);
    idle(6);
    rd(RXST, d);  check("R5 disabled nothing stored", 32'(d), 32'h0);
    ir_in = 1'b0;
    idle(4);
    wr(CTRL, 16'd3);
    idle(10);
    ir_in = 1'b1;
    idle(8);
    pulse(7, 45); expect_pair(7, 16'hFFFF);
    idle(6);
    rd(RXST, d);  check("R5 one entry after enable", 32'(d), 32'h0100);
    drain("R5");
    wr(CTRL, 16'd0); ir_in = 1'b0; act = 1'b1; idle(4); wr(CTRL, 16'd1); idle(4);

    // R8: overflow
    wr(ICLR, 16'hF);
    for (int i = 0; i < 9; i++) pulse(3, 5);
    pulse(3, 50);
    for (int i = 0; i < 8; i++) expect_pair(3, 8);
    idle(6);
    rd(ISTAT, d); check("R8 status all", 32'(d), 32'hF);
    rd(RXST, d);  check("R11 R8 full and overrun", 32'(d), 32'h0804);
    drain("R8");
    rd(RXST, d);  check("R8 overrun kept", 32'(d), 32'h0004);
    wr(ICLR, 16'h4);
    rd(RXST, d);  check("R9 R8 overrun cleared", 32'(d), 32'h0);

    // R6: divisor 4, then divisor 0
    wr(ICLR, 16'hF);
    wr(DIVR, 16'd4); idle(4);
    pulse(12, 20); expect_pair(3, 8);
    pulse(8, 200); expect_pair(2, 16'hFFFF);
    idle(12);
    drain("R6 div4");
    wr(DIVR, 16'd0); idle(4);
    pulse(5, 5);  expect_pair(5, 10);
    pulse(2, 45); expect_pair(2, 16'hFFFF);
    idle(6);
    drain("R6 div0");

    // R12: saturation
    wr(DIVR, 16'd1); idle(4);
    pulse(66000, 60); expect_pair(16'hFFFF, 16'hFFFF);
    idle(6);
    drain("R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule